// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block sits in the decode stage of a two-wide in-order front end. In each cycle it receives two decoded instructions in program order, an older slot and a younger slot, and decides whether the pair can issue together. If the pair cannot issue together, only the older instruction issues. For every instruction the block sees a valid bit, a destination register with a write-enable, and an operation class. For the younger instruction it also sees two source registers, each with its own read flag. The older slot's sources never decide a conflict inside the pair, so they are not ports.

The younger instruction is refused a partner slot in three cases. The first is a true dependence: it reads a register that the older instruction writes. The second is an output dependence: both instructions write the same register. The third is a structural conflict: both instructions need a unit that exists only once, which by default is the single divider. In any of these cases the older instruction issues alone and the hold output is raised. The decode group then presents the held instruction again as the older slot in the next cycle, paired with the next incoming instruction, so program order is kept. The decision is registered, and it appears one clock after the slots are presented.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three decision outputs become 0 after that edge.
- R2: `issue_old` equals the `old_valid` value sampled at the previous rising edge (while out of reset).
- R3: If the older slot writes (`old_wr_en`=1) register D, and the younger slot reads D through source A or source B with that source's read flag set, then `issue_young` is 0 and `hold_young` is 1 on the next cycle (when both slots are valid).
- R4: If both slots are valid, both write-enables are set and both destinations are equal, then `issue_young` is 0 and `hold_young` is 1 on the next cycle.
- R5: If both valid slots carry operation class 2 (divide), the pair never issues together. A single divide paired with a non-divide class (0 = ALU, 1 = multiply, 3 = memory) causes no conflict.
- R6: A younger source whose read flag is 0, or a destination whose write-enable is 0, never causes a conflict, whatever register index it holds.
- R7: Register index 0 is compared like any other index, so a write to register 0 followed by a read of register 0 is a true dependence.
- R8: When `old_valid` is 0, neither slot issues on the next cycle, and `hold_young` equals the sampled `yng_valid`.
- R9: When `old_valid` is 1 and `yng_valid` is 0, the older slot issues alone and `hold_young` is 0.
- R10: Two valid slots that have no true, output or structural conflict both issue, and `hold_young` is 0.
- R11: `issue_young` is never 1 unless `issue_old` is 1, and `issue_young` and `hold_young` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| old_valid | input | 1 | Older slot holds an instruction |
| old_dest | input | REG_W | Older destination register |
| old_wr_en | input | 1 | Older instruction writes its destination |
| old_class | input | CLS_W | Older operation class (2 = divide) |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_dest | input | REG_W | Younger destination register |
| yng_wr_en | input | 1 | Younger instruction writes its destination |
| yng_src_a | input | REG_W | Younger first source register |
| yng_rd_a | input | 1 | First source is read |
| yng_src_b | input | REG_W | Younger second source register |
| yng_rd_b | input | 1 | Second source is read |
| yng_class | input | CLS_W | Younger operation class (2 = divide) |
| issue_old | output | 1 | Older instruction issues this cycle |
| issue_young | output | 1 | Younger instruction issues alongside the older one |
| hold_young | output | 1 | Younger instruction is kept for the next cycle |

## Verification
Every decision is registered and is overwritten on every clock, so a wrong comparison shows at the ports one cycle after the offending pair and lasts for one cycle only. A missed conflict shows up as `issue_young` raised when it should be low. A false conflict shows up as `hold_young` raised for an independent pair, and the pipeline loses a slot without any error being visible. The bench therefore compares each registered decision against a model it computes itself, over directed pairs and random pairs drawn from a small register range so that collisions are frequent. It also checks the ordering invariants between the three outputs.

// File: rtl/dip_pkg.sv
// Package: shared types for the dual-issue pair checker.
// Assumes a two-bit operation class with one single-instance unit (divide).
package dip_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_MEM = 2'd3
    } op_class_e;

    typedef struct packed {
        logic issue_old;
        logic issue_young;
        logic hold_young;
    } issue_dec_t;

endpackage

// File: rtl/pair_dep_cmp.sv
// Module: pair_dep_cmp
// Finds register dependences of the younger slot on the older slot:
// true dependence through any read source, and output dependence on the
// destination. Purely combinational. Assumes validity is applied by the caller.
module pair_dep_cmp #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic [REG_W-1:0]            old_dest,
    input  logic                        old_wr_en,
    input  logic [NSRC-1:0][REG_W-1:0]  yng_src,
    input  logic [NSRC-1:0]             yng_rd,
    input  logic [REG_W-1:0]            yng_dest,
    input  logic                        yng_wr_en,
    output logic                        raw_hit,
    output logic                        waw_hit
);

    logic [NSRC-1:0] src_hit;

    // One comparator per younger source; a source counts only when read.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_hit[g] = old_wr_en & yng_rd[g] & (yng_src[g] == old_dest);
    end

    // Reduce source hits into a single true-dependence flag.
    assign raw_hit = |src_hit;

    // Output dependence needs both writers enabled on the same index.
    assign waw_hit = old_wr_en & yng_wr_en & (yng_dest == old_dest);

endmodule

// File: rtl/pair_unit_cmp.sv
// Module: pair_unit_cmp
// Flags a structural conflict when both slots need a unit that exists once.
// The single-instance classes are listed in SINGLE_CLS, CLS_W bits each.
module pair_unit_cmp #(
    parameter int                        CLS_W      = 2,
    parameter int                        NSINGLE    = 1,
    parameter logic [NSINGLE*CLS_W-1:0]  SINGLE_CLS = 2'd2
) (
    input  logic [CLS_W-1:0] old_class,
    input  logic [CLS_W-1:0] yng_class,
    output logic             unit_hit
);

    logic [NSINGLE-1:0] cls_hit;

    // One match per single-instance class: both slots claim the same unit.
    for (genvar g = 0; g < NSINGLE; g++) begin : g_unit
        assign cls_hit[g] = (old_class == SINGLE_CLS[g*CLS_W +: CLS_W]) &&
                            (yng_class == SINGLE_CLS[g*CLS_W +: CLS_W]);
    end

    // Any shared single unit blocks pairing.
    assign unit_hit = |cls_hit;

endmodule

// File: rtl/pair_issue_ctl.sv
// Module: pair_issue_ctl
// Turns validity and hazard flags into the registered issue decision.
// Assumes hazard flags are computed from the same-cycle slot contents.
module pair_issue_ctl
    import dip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       old_valid,
    input  logic       yng_valid,
    input  logic       raw_hit,
    input  logic       waw_hit,
    input  logic       unit_hit,
    output issue_dec_t dec_q
);

    issue_dec_t dec_d;
    logic       pair_ok;

    // Next decision: older issues when valid, younger only when independent.
    always_comb begin
        pair_ok           = yng_valid & ~raw_hit & ~waw_hit & ~unit_hit;
        dec_d.issue_old   = old_valid;
        dec_d.issue_young = old_valid & pair_ok;
        dec_d.hold_young  = yng_valid & ~(old_valid & pair_ok);
    end

    // Decision register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

endmodule

// File: rtl/dual_issue_pairer.sv
// Module: dual_issue_pairer (top)
// Decides per cycle whether an older/younger instruction pair issues together.
// Assumes slots arrive in program order; a held younger slot is re-presented
// upstream as the next older slot. Decision latency is one clock.
module dual_issue_pairer
    import dip_pkg::*;
#(
    parameter int                        REG_W      = 5,
    parameter int                        CLS_W      = 2,
    parameter int                        NSINGLE    = 1,
    parameter logic [NSINGLE*CLS_W-1:0]  SINGLE_CLS = CLS_W'(CLS_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             old_valid,
    input  logic [REG_W-1:0] old_dest,
    input  logic             old_wr_en,
    input  logic [CLS_W-1:0] old_class,
    input  logic             yng_valid,
    input  logic [REG_W-1:0] yng_dest,
    input  logic             yng_wr_en,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic             yng_rd_a,
    input  logic [REG_W-1:0] yng_src_b,
    input  logic             yng_rd_b,
    input  logic [CLS_W-1:0] yng_class,
    output logic             issue_old,
    output logic             issue_young,
    output logic             hold_young
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_W-1:0] src_vec;
    logic [NSRC-1:0]            rd_vec;
    logic                       raw_hit;
    logic                       waw_hit;
    logic                       unit_hit;
    issue_dec_t                 dec_q;

    // Gather younger sources into indexed form for the comparator array.
    assign src_vec = {yng_src_b, yng_src_a};
    assign rd_vec  = {yng_rd_b, yng_rd_a};

    pair_dep_cmp #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_dep (
        .old_dest  (old_dest),
        .old_wr_en (old_wr_en),
        .yng_src   (src_vec),
        .yng_rd    (rd_vec),
        .yng_dest  (yng_dest),
        .yng_wr_en (yng_wr_en),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit)
    );

    pair_unit_cmp #(
        .CLS_W      (CLS_W),
        .NSINGLE    (NSINGLE),
        .SINGLE_CLS (SINGLE_CLS)
    ) u_unit (
        .old_class (old_class),
        .yng_class (yng_class),
        .unit_hit  (unit_hit)
    );

    pair_issue_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .old_valid (old_valid),
        .yng_valid (yng_valid),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit),
        .unit_hit  (unit_hit),
        .dec_q     (dec_q)
    );

    // Drive the registered decision onto the ports.
    assign issue_old   = dec_q.issue_old;
    assign issue_young = dec_q.issue_young;
    assign hold_young  = dec_q.hold_young;

endmodule

// File: rtl/dual_issue_pairer_chk.sv
// Module: dual_issue_pairer_chk
// Port-level property checks for dual_issue_pairer, attached by bind.
// Assumes the default divide class code 2 for the structural rule.
module dual_issue_pairer_chk #(
    parameter int REG_W = 5,
    parameter int CLS_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             old_valid,
    input logic [REG_W-1:0] old_dest,
    input logic             old_wr_en,
    input logic [CLS_W-1:0] old_class,
    input logic             yng_valid,
    input logic [REG_W-1:0] yng_dest,
    input logic             yng_wr_en,
    input logic [REG_W-1:0] yng_src_a,
    input logic             yng_rd_a,
    input logic             yng_src_b_unused_guard,
    input logic             issue_old,
    input logic             issue_young,
    input logic             hold_young
);

    localparam logic [CLS_W-1:0] DIV_CODE = CLS_W'(2);

    logic both_valid;
    assign both_valid = old_valid & yng_valid;

    // Reset clears every decision output.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!issue_old && !issue_young && !hold_young));

    // Older issue follows the sampled older valid bit.
    assert_old_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (issue_old == $past(old_valid)));

    // True dependence through source A blocks pairing.
    assert_raw_src_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (both_valid && old_wr_en && yng_rd_a && (yng_src_a == old_dest))
        |=> (!issue_young && hold_young));

    // Output dependence blocks pairing.
    assert_waw_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (both_valid && old_wr_en && yng_wr_en && (yng_dest == old_dest))
        |=> (!issue_young && hold_young));

    // Two divides never pair.
    assert_two_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (both_valid && old_class == DIV_CODE && yng_class_is_div)
        |=> !issue_young);

    // An empty older slot issues nothing.
    assert_no_old_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !old_valid |=> (!issue_old && !issue_young));

    // Younger never issues without the older, and is never both issued and held.
    assert_young_needs_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_young |-> issue_old);
    assert_issue_hold_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_young && hold_young));

    logic yng_class_is_div;
    assign yng_class_is_div = yng_src_b_unused_guard;

endmodule

bind dual_issue_pairer dual_issue_pairer_chk #(
    .REG_W (REG_W),
    .CLS_W (CLS_W)
) u_chk (
    .clk                    (clk),
    .rst_n                  (rst_n),
    .old_valid              (old_valid),
    .old_dest               (old_dest),
    .old_wr_en              (old_wr_en),
    .old_class              (old_class),
    .yng_valid              (yng_valid),
    .yng_dest               (yng_dest),
    .yng_wr_en              (yng_wr_en),
    .yng_src_a              (yng_src_a),
    .yng_rd_a               (yng_rd_a),
    .yng_src_b_unused_guard (yng_class == CLS_W'(2)),
    .issue_old              (issue_old),
    .issue_young            (issue_young),
    .hold_young             (hold_young)
);

// File: tb/test_dual_issue_pairer.sv
// Bench for dual_issue_pairer: vector table, random pairs against a model,
// then directed reset and re-presentation tests.
module test_dual_issue_pairer;

    typedef struct packed {
        logic       v;
        logic [4:0] d;
        logic       w;
        logic [4:0] sa;
        logic       ra;
        logic [4:0] sb;
        logic       rb;
        logic [1:0] c;
    } ins_t;

    typedef struct packed {
        ins_t       o;
        ins_t       y;
        logic [2:0] e;   // {issue_old, issue_young, hold_young}
    } vec_t;

    function automatic ins_t mi(bit v, int d, bit w, int sa, bit ra,
                                int sb, bit rb, int c);
        ins_t r;
        r.v = v; r.d = 5'(d); r.w = w; r.sa = 5'(sa); r.ra = ra;
        r.sb = 5'(sb); r.rb = rb; r.c = 2'(c);
        return r;
    endfunction

    // Model from the requirements: class 2 is divide.
    function automatic logic [2:0] model(ins_t o, ins_t y);
        logic raw, waw, dv, ok;
        raw = o.w && ((y.ra && y.sa == o.d) || (y.rb && y.sb == o.d));
        waw = o.w && y.w && (y.d == o.d);
        dv  = (o.c == 2'd2) && (y.c == 2'd2);
        ok  = y.v && !raw && !waw && !dv;
        return {o.v, o.v && ok, y.v && !(o.v && ok)};
    endfunction

    localparam int NV = 14;
    localparam vec_t TAB [NV] = '{
        '{mi(1,3,1,1,1,2,1,0), mi(1,4,1,5,1,6,1,1), 3'b110}, // R10 independent
        '{mi(1,3,1,1,1,2,1,0), mi(1,4,1,3,1,6,1,0), 3'b101}, // R3 via source A
        '{mi(1,4,1,3,1,6,1,0), mi(1,7,1,8,1,9,1,0), 3'b110}, // R10 held slot re-presented as older
        '{mi(1,3,1,1,1,2,1,0), mi(1,4,1,5,1,3,1,3), 3'b101}, // R3 via source B
        '{mi(1,3,1,1,1,2,1,0), mi(1,4,1,3,0,3,0,0), 3'b110}, // R6 read flags clear
        '{mi(1,3,1,1,1,2,1,0), mi(1,3,1,5,1,6,1,0), 3'b101}, // R4 same destination
        '{mi(1,3,1,1,1,2,1,0), mi(1,3,0,5,1,6,1,0), 3'b110}, // R6 younger write-enable clear
        '{mi(1,3,0,1,1,2,1,0), mi(1,3,1,3,1,3,1,0), 3'b110}, // R6 older write-enable clear
        '{mi(1,3,1,1,1,2,1,2), mi(1,4,1,5,1,6,1,2), 3'b101}, // R5 two divides
        '{mi(1,3,1,1,1,2,1,2), mi(1,4,1,5,1,6,1,1), 3'b110}, // R5 one divide
        '{mi(1,0,1,1,1,2,1,0), mi(1,4,1,0,1,6,1,0), 3'b101}, // R7 register 0 dependence
        '{mi(0,3,1,1,1,2,1,0), mi(1,4,1,5,1,6,1,0), 3'b001}, // R8 older empty
        '{mi(1,3,1,1,1,2,1,0), mi(0,3,1,3,1,3,1,2), 3'b100}, // R9 younger empty
        '{mi(0,3,1,1,1,2,1,0), mi(0,4,1,5,1,6,1,0), 3'b000}  // R8 both empty
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    ins_t       o_in = '0;
    ins_t       y_in = '0;
    logic       issue_old, issue_young, hold_young;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dual_issue_pairer i_dual_issue_pairer (
        .clk         (clk),
        .rst_n       (rst_n),
        .old_valid   (o_in.v),
        .old_dest    (o_in.d),
        .old_wr_en   (o_in.w),
        .old_class   (o_in.c),
        .yng_valid   (y_in.v),
        .yng_dest    (y_in.d),
        .yng_wr_en   (y_in.w),
        .yng_src_a   (y_in.sa),
        .yng_rd_a    (y_in.ra),
        .yng_src_b   (y_in.sb),
        .yng_rd_b    (y_in.rb),
        .yng_class   (y_in.c),
        .issue_old   (issue_old),
        .issue_young (issue_young),
        .hold_young  (hold_young)
    );

    task automatic check(string req, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    // Drive a pair after a falling edge and sample one full clock later.
    task automatic apply(ins_t o, ins_t y);
        o_in = o;
        y_in = y;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: outputs clear while held in reset, even with valid slots.
        apply(TAB[0].o, TAB[0].y);
        check("R1", {issue_old, issue_young, hold_young}, 3'b000);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            apply(TAB[i].o, TAB[i].y);
            check($sformatf("table[%0d] R2..R10", i),
                  {issue_old, issue_young, hold_young}, TAB[i].e);
        end

        // Random pairs on a narrow register range to force collisions.
        for (int i = 0; i < 400; i++) begin
            ins_t ro, ry;
            ro = mi($urandom_range(0, 7) != 0, $urandom_range(0, 3), $urandom_range(0, 1),
                    $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
                    $urandom_range(0, 1), $urandom_range(0, 3));
            ry = mi($urandom_range(0, 7) != 0, $urandom_range(0, 3), $urandom_range(0, 1),
                    $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
                    $urandom_range(0, 1), $urandom_range(0, 3));
            apply(ro, ry);
            check("R3/R4/R5/R6 random", {issue_old, issue_young, hold_young}, model(ro, ry));
            check("R11 ordering", {1'b0, issue_young && !issue_old, issue_young && hold_young},
                  3'b000);
        end

        // R7: output dependence on register 0.
        apply(mi(1,0,1,1,1,2,1,0), mi(1,0,1,5,1,6,1,0));
        check("R7 waw r0", {issue_old, issue_young, hold_young}, 3'b101);

        // R1: mid-run reset clears a pending issue.
        o_in = TAB[0].o;
        y_in = TAB[0].y;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run", {issue_old, issue_young, hold_young}, 3'b000);
        rst_n = 1'b1;
        apply(TAB[0].o, TAB[0].y);
        check("R10 after reset", {issue_old, issue_young, hold_young}, 3'b110);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule